// File: doc/BRIEF.md
# Serial flash status and write-permission controller

This block keeps the 16-bit status word of a serial flash device and decides which decoded instructions may change it. Upstream logic passes in one strobe per completed instruction, with its 8-bit opcode and, for a status write, the two data bytes already joined into one 16-bit word. The block updates the busy flag, the write-enable latch, the protection, quad-enable, lock and suspend bits from these strobes and from an operation-done pulse sent by the array engine. It also reports when a program, erase or status-write command has been accepted, so that the array engine can start it.

Permission to write depends on several things: the write-enable latch, the two status-protection bits, the write-protect pin (only when quad mode is off), a pending suspend, a running operation, and the power-down state. Status reads return either byte of the word one cycle after the strobe. A separate power-cycle input models supply loss. It clears the volatile state and keeps the non-volatile bits, except for the one protection setting that a power cycle releases.

Top module: `flash_status_ctrl`

## Requirements
- R1: After reset, status_o is 0x0000, and power_down_o, op_start_o and rd_valid_o are all 0.
- R2: Opcode 0x06 sets the write-enable latch (status bit 1). Opcode 0x04 clears it.
- R3: Program and erase opcodes (0x02, 0x32, 0x20, 0x52, 0xD8, 0xC7, 0x60, 0x44, 0x42) and the status write 0x01 are accepted only when all of these hold: the latch is 1, busy (bit 0) is 0, suspend (bit 15) is 0, and the block is not powered down. When a command is accepted, op_start_o pulses for one cycle with op_code_o equal to the opcode, and busy reads 1 from the cycle after the strobe.
- R4: An op_done_i pulse while busy clears both busy and the write-enable latch in the following cycle. While not busy, op_done_i has no effect.
- R5: While busy, only 0x05, 0x35 and 0x75 have any effect. All other opcodes are ignored.
- R6: An accepted status write loads data bits 2 to 9 and 14 (BP0..BP2, TB, SEC, SRP0, SRP1, QE, CMP) into the same status positions. Data bits 0, 1, 10 and 15 are ignored.
- R7: The lock bits 11 to 13 (LB1..LB3) are set by data ones in a status write and clear only on reset.
- R8: While qpi_mode_i is 1, a status write cannot clear QE (bit 9). With qpi_mode_i at 0, QE can be cleared.
- R9: Status writes are refused while SRP1 (bit 8) is 1. With SRP1=0 and SRP0 (bit 7) =1, they are also refused while wp_ni is 0 and QE is 0.
- R10: Opcode 0x75, issued while a program or erase is busy, clears busy and sets suspend. It is ignored during a status write. Opcode 0x7A, issued while suspended, clears suspend and sets busy. While suspended, program, erase and status write are refused.
- R11: Opcode 0xB9, issued while not busy, sets power_down_o and clears suspend. While powered down, every opcode except 0xAB is ignored, and that includes status reads. 0xAB clears power_down_o.
- R12: A pwr_cycle_i pulse clears busy, the write-enable latch, suspend and power-down. It changes SRP1,SRP0 = (1,0) to (0,0) and keeps every other non-volatile bit.
- R13: Opcode 0x05 gives rd_valid_o=1 in the next cycle, with rd_byte_o equal to status bits 7:0. Opcode 0x35 does the same with bits 15:8. The value returned is the status held during the strobe cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset to factory state |
| pwr_cycle_i | input | 1 | One-cycle pulse marking a supply loss and return |
| cmd_valid_i | input | 1 | Decoded instruction strobe |
| cmd_code_i | input | 8 | Instruction opcode |
| cmd_data_i | input | 16 | Status-write data, aligned to status bit positions |
| qpi_mode_i | input | 1 | Device is in four-wire instruction mode |
| wp_ni | input | 1 | Write-protect pin, active low |
| op_done_i | input | 1 | Array engine finished the running operation |
| status_o | output | 16 | Current status word |
| power_down_o | output | 1 | Deep power-down state |
| op_start_o | output | 1 | Accepted program, erase or status-write pulse |
| op_code_o | output | 8 | Opcode of the accepted operation |
| rd_valid_o | output | 1 | Status read byte valid |
| rd_byte_o | output | 8 | Status read byte |

## Verification
The bench builds the block with its default parameters: three lock bits, pin gating enabled, quad page program and the security-register opcodes classed as array operations, and a registered read port. This setting covers every lock position, the dependence of pin gating on QE, and the one-cycle read latency. Random opcode streams with random op_done, power-cycle and reset pulses then reach interleavings that the directed cases do not, such as suspend arriving in the same cycle as completion, or power-down entered while suspended.

// File: rtl/flash_stat_pkg.sv
`timescale 1ns/1ps
package flash_stat_pkg;
   localparam int STAT_W    = 16;
   localparam int OPC_W     = 8;
   localparam int MAX_LOCKS = 3;

   localparam int B_BUSY = 0;
   localparam int B_WEL  = 1;
   localparam int B_BP0  = 2;
   localparam int B_SRP0 = 7;
   localparam int B_SRP1 = 8;
   localparam int B_QE   = 9;
   localparam int B_RSV  = 10;
   localparam int B_LB1  = 11;
   localparam int B_CMP  = 14;
   localparam int B_SUS  = 15;

   localparam logic [OPC_W-1:0] OP_WREN    = 8'h06;
   localparam logic [OPC_W-1:0] OP_WRDI    = 8'h04;
   localparam logic [OPC_W-1:0] OP_STWR    = 8'h01;
   localparam logic [OPC_W-1:0] OP_RDLO    = 8'h05;
   localparam logic [OPC_W-1:0] OP_RDHI    = 8'h35;
   localparam logic [OPC_W-1:0] OP_SUSP    = 8'h75;
   localparam logic [OPC_W-1:0] OP_RESUME  = 8'h7A;
   localparam logic [OPC_W-1:0] OP_PDOWN   = 8'hB9;
   localparam logic [OPC_W-1:0] OP_WAKE    = 8'hAB;
   localparam logic [OPC_W-1:0] OP_PROG    = 8'h02;
   localparam logic [OPC_W-1:0] OP_QPROG   = 8'h32;
   localparam logic [OPC_W-1:0] OP_ER4K    = 8'h20;
   localparam logic [OPC_W-1:0] OP_ER32K   = 8'h52;
   localparam logic [OPC_W-1:0] OP_ER64K   = 8'hD8;
   localparam logic [OPC_W-1:0] OP_ERALL_A = 8'hC7;
   localparam logic [OPC_W-1:0] OP_ERALL_B = 8'h60;
   localparam logic [OPC_W-1:0] OP_SECER   = 8'h44;
   localparam logic [OPC_W-1:0] OP_SECPG   = 8'h42;

   typedef enum logic [3:0] {
      CC_NONE, CC_WREN, CC_WRDI, CC_ARRAY, CC_STWR, CC_RDLO,
      CC_RDHI, CC_SUSP, CC_RESUME, CC_PDOWN, CC_WAKE
   } cmd_class_e;

   typedef struct packed {
      logic wren;
      logic wrdi;
      logic array_op;
      logic stwr;
      logic rdlo;
      logic rdhi;
      logic susp;
      logic resume;
      logic pdown;
      logic wake;
   } grant_t;
endpackage

// File: rtl/flash_cmd_class.sv
`timescale 1ns/1ps
module flash_cmd_class
   import flash_stat_pkg::*;
#(
   parameter bit QUAD_PROG_EN = 1'b1,
   parameter bit SEC_REG_EN   = 1'b1
) (
   input  logic             valid_i,
   input  logic [OPC_W-1:0] code_i,
   output cmd_class_e       cls_o
);
   localparam cmd_class_e QPROG_CLS = QUAD_PROG_EN ? CC_ARRAY : CC_NONE;
   localparam cmd_class_e SEC_CLS   = SEC_REG_EN   ? CC_ARRAY : CC_NONE;

   always_comb begin
      cls_o = CC_NONE;
      if (valid_i) begin
         case (code_i)
            OP_WREN:                 cls_o = CC_WREN;
            OP_WRDI:                 cls_o = CC_WRDI;
            OP_STWR:                 cls_o = CC_STWR;
            OP_RDLO:                 cls_o = CC_RDLO;
            OP_RDHI:                 cls_o = CC_RDHI;
            OP_SUSP:                 cls_o = CC_SUSP;
            OP_RESUME:               cls_o = CC_RESUME;
            OP_PDOWN:                cls_o = CC_PDOWN;
            OP_WAKE:                 cls_o = CC_WAKE;
            OP_PROG, OP_ER4K, OP_ER32K, OP_ER64K,
            OP_ERALL_A, OP_ERALL_B:  cls_o = CC_ARRAY;
            OP_QPROG:                cls_o = QPROG_CLS;
            OP_SECER, OP_SECPG:      cls_o = SEC_CLS;
            default:                 cls_o = CC_NONE;
         endcase
      end
   end
endmodule

// File: rtl/flash_wr_permit.sv
`timescale 1ns/1ps
module flash_wr_permit
   import flash_stat_pkg::*;
#(
   parameter bit HW_PIN_GATE = 1'b1
) (
   input  cmd_class_e cls_i,
   input  logic       busy_i,
   input  logic       busy_is_stwr_i,
   input  logic       sus_i,
   input  logic       pd_i,
   input  logic       op_done_i,
   input  logic       wel_i,
   input  logic       srp0_i,
   input  logic       srp1_i,
   input  logic       qe_i,
   input  logic       wp_ni,
   output grant_t     grant_o
);
   logic pin_block;
   logic stwr_ok;

   generate
      if (HW_PIN_GATE) begin : g_pin_gate
         assign pin_block = srp0_i & ~srp1_i & ~qe_i & ~wp_ni;
      end else begin : g_no_pin_gate
         logic unused_pin;
         assign unused_pin = ^{srp0_i, qe_i, wp_ni};
         assign pin_block  = 1'b0;
      end
   endgenerate

   assign stwr_ok = ~srp1_i & ~pin_block;

   always_comb begin
      grant_o = '0;
      if (pd_i) begin
         grant_o.wake = (cls_i == CC_WAKE);
      end else if (busy_i) begin
         grant_o.rdlo = (cls_i == CC_RDLO);
         grant_o.rdhi = (cls_i == CC_RDHI);
         grant_o.susp = (cls_i == CC_SUSP) & ~busy_is_stwr_i & ~op_done_i;
      end else begin
         case (cls_i)
            CC_WREN:   grant_o.wren     = 1'b1;
            CC_WRDI:   grant_o.wrdi     = 1'b1;
            CC_RDLO:   grant_o.rdlo     = 1'b1;
            CC_RDHI:   grant_o.rdhi     = 1'b1;
            CC_PDOWN:  grant_o.pdown    = 1'b1;
            CC_RESUME: grant_o.resume   = sus_i;
            CC_ARRAY:  grant_o.array_op = wel_i & ~sus_i;
            CC_STWR:   grant_o.stwr     = wel_i & ~sus_i & stwr_ok;
            default:   grant_o          = '0;
         endcase
      end
   end
endmodule

// File: rtl/flash_nv_merge.sv
`timescale 1ns/1ps
module flash_nv_merge
   import flash_stat_pkg::*;
#(
   parameter int NUM_LOCKS = MAX_LOCKS
) (
   input  logic [STAT_W-1:0]    data_i,
   input  logic                 old_qe_i,
   input  logic [MAX_LOCKS-1:0] old_locks_i,
   input  logic                 qpi_i,
   output logic [STAT_W-1:0]    nv_o
);
   logic [MAX_LOCKS-1:0] locks_nxt;
   logic                 unused_data;

   assign unused_data = ^{data_i[B_BUSY], data_i[B_WEL], data_i[B_RSV], data_i[B_SUS]};

   for (genvar i = 0; i < MAX_LOCKS; i++) begin : g_lock
      if (i < NUM_LOCKS) begin : g_used
         assign locks_nxt[i] = old_locks_i[i] | data_i[B_LB1+i];
      end else begin : g_absent
         logic unused_lock;
         assign unused_lock  = old_locks_i[i] ^ data_i[B_LB1+i];
         assign locks_nxt[i] = 1'b0;
      end
   end

   always_comb begin
      nv_o                         = '0;
      nv_o[B_SRP1:B_BP0]           = data_i[B_SRP1:B_BP0];
      nv_o[B_QE]                   = data_i[B_QE] | (qpi_i & old_qe_i);
      nv_o[B_LB1 +: MAX_LOCKS]     = locks_nxt;
      nv_o[B_CMP]                  = data_i[B_CMP];
   end
endmodule

// File: rtl/flash_stat_read.sv
`timescale 1ns/1ps
module flash_stat_read
   import flash_stat_pkg::*;
#(
   parameter bit REGISTERED = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              rd_lo_i,
   input  logic              rd_hi_i,
   input  logic [STAT_W-1:0] status_i,
   output logic              rd_valid_o,
   output logic [7:0]        rd_byte_o
);
   localparam int HALF = STAT_W / 2;

   logic [7:0] sel_byte;
   assign sel_byte = rd_hi_i ? status_i[STAT_W-1:HALF] : status_i[HALF-1:0];

   generate
      if (REGISTERED) begin : g_reg
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               rd_valid_o <= 1'b0;
               rd_byte_o  <= '0;
            end else begin
               rd_valid_o <= rd_lo_i | rd_hi_i;
               if (rd_lo_i | rd_hi_i) rd_byte_o <= sel_byte;
            end
         end
      end else begin : g_comb
         logic unused_clk;
         assign unused_clk = clk_i ^ rst_ni;
         assign rd_valid_o = rd_lo_i | rd_hi_i;
         assign rd_byte_o  = sel_byte;
      end
   endgenerate

   always_comb begin
      assert (!(rd_lo_i && rd_hi_i)) else $error("assert_one_read_R13");
   end
endmodule

// File: rtl/flash_status_ctrl.sv
`timescale 1ns/1ps
module flash_status_ctrl
   import flash_stat_pkg::*;
#(
   parameter int NUM_LOCKS       = 3,
   parameter bit HW_PIN_GATE     = 1'b1,
   parameter bit QUAD_PROG_EN    = 1'b1,
   parameter bit SEC_REG_EN      = 1'b1,
   parameter bit READ_REGISTERED = 1'b1
) (
   input  logic        clk_i,
   input  logic        rst_ni,
   input  logic        pwr_cycle_i,
   input  logic        cmd_valid_i,
   input  logic [7:0]  cmd_code_i,
   input  logic [15:0] cmd_data_i,
   input  logic        qpi_mode_i,
   input  logic        wp_ni,
   input  logic        op_done_i,
   output logic [15:0] status_o,
   output logic        power_down_o,
   output logic        op_start_o,
   output logic [7:0]  op_code_o,
   output logic        rd_valid_o,
   output logic [7:0]  rd_byte_o
);
   localparam int LOCK_HI = B_LB1 + MAX_LOCKS - 1;

   initial begin
      if (NUM_LOCKS < 1 || NUM_LOCKS > MAX_LOCKS)
         $fatal(1, "NUM_LOCKS must lie in 1..%0d", MAX_LOCKS);
      if (STAT_W != 16 || OPC_W != 8)
         $fatal(1, "status word must be 16 bits and opcodes 8 bits");
   end

   logic [STAT_W-1:0] nv_q, nv_merged;
   logic              busy_q, busy_sw_q, wel_q, sus_q, pd_q;
   logic              op_start_q;
   logic [OPC_W-1:0]  op_code_q;
   cmd_class_e        cls;
   grant_t            grant;

   flash_cmd_class #(
      .QUAD_PROG_EN (QUAD_PROG_EN),
      .SEC_REG_EN   (SEC_REG_EN)
   ) i_class (
      .valid_i (cmd_valid_i & ~pwr_cycle_i),
      .code_i  (cmd_code_i),
      .cls_o   (cls)
   );

   flash_wr_permit #(
      .HW_PIN_GATE (HW_PIN_GATE)
   ) i_permit (
      .cls_i          (cls),
      .busy_i         (busy_q),
      .busy_is_stwr_i (busy_sw_q),
      .sus_i          (sus_q),
      .pd_i           (pd_q),
      .op_done_i      (op_done_i),
      .wel_i          (wel_q),
      .srp0_i         (nv_q[B_SRP0]),
      .srp1_i         (nv_q[B_SRP1]),
      .qe_i           (nv_q[B_QE]),
      .wp_ni          (wp_ni),
      .grant_o        (grant)
   );

   flash_nv_merge #(
      .NUM_LOCKS (NUM_LOCKS)
   ) i_merge (
      .data_i      (cmd_data_i),
      .old_qe_i    (nv_q[B_QE]),
      .old_locks_i (nv_q[LOCK_HI:B_LB1]),
      .qpi_i       (qpi_mode_i),
      .nv_o        (nv_merged)
   );

   always_comb begin
      status_o         = nv_q;
      status_o[B_BUSY] = busy_q;
      status_o[B_WEL]  = wel_q;
      status_o[B_SUS]  = sus_q;
   end

   flash_stat_read #(
      .REGISTERED (READ_REGISTERED)
   ) i_read (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .rd_lo_i    (grant.rdlo),
      .rd_hi_i    (grant.rdhi),
      .status_i   (status_o),
      .rd_valid_o (rd_valid_o),
      .rd_byte_o  (rd_byte_o)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         nv_q       <= '0;
         busy_q     <= 1'b0;
         busy_sw_q  <= 1'b0;
         wel_q      <= 1'b0;
         sus_q      <= 1'b0;
         pd_q       <= 1'b0;
         op_start_q <= 1'b0;
         op_code_q  <= '0;
      end else if (pwr_cycle_i) begin
         busy_q     <= 1'b0;
         busy_sw_q  <= 1'b0;
         wel_q      <= 1'b0;
         sus_q      <= 1'b0;
         pd_q       <= 1'b0;
         op_start_q <= 1'b0;
         if (nv_q[B_SRP1] && !nv_q[B_SRP0]) nv_q[B_SRP1] <= 1'b0;
      end else begin
         op_start_q <= 1'b0;
         if (busy_q && op_done_i) begin
            busy_q <= 1'b0;
            wel_q  <= 1'b0;
         end
         if (grant.wren) wel_q <= 1'b1;
         if (grant.wrdi) wel_q <= 1'b0;
         if (grant.array_op || grant.stwr) begin
            busy_q     <= 1'b1;
            busy_sw_q  <= grant.stwr;
            op_start_q <= 1'b1;
            op_code_q  <= cmd_code_i;
         end
         if (grant.stwr) nv_q <= nv_merged;
         if (grant.susp) begin
            busy_q <= 1'b0;
            sus_q  <= 1'b1;
         end
         if (grant.resume) begin
            busy_q <= 1'b1;
            sus_q  <= 1'b0;
         end
         if (grant.pdown) begin
            pd_q  <= 1'b1;
            sus_q <= 1'b0;
         end
         if (grant.wake) pd_q <= 1'b0;
      end
   end

   assign power_down_o = pd_q;
   assign op_start_o   = op_start_q;
   assign op_code_o    = op_code_q;

   // R3: an accepted operation is busy and was write-enabled
   assert_start_needs_wel_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      op_start_o |-> (status_o[B_BUSY] && $past(status_o[B_WEL])));

   // R4: completion clears busy and the write-enable latch
   assert_done_clears_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (status_o[B_BUSY] && op_done_i && !pwr_cycle_i)
      |=> (!status_o[B_BUSY] && !status_o[B_WEL]));

   // R7: lock bits never fall while out of reset
   assert_lock_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|status_o[LOCK_HI:B_LB1])
      |=> ((status_o[LOCK_HI:B_LB1] & $past(status_o[LOCK_HI:B_LB1]))
           == $past(status_o[LOCK_HI:B_LB1])));

   // R8: QE cannot drop because of a command issued in four-wire mode
   assert_qe_hold_qpi_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (qpi_mode_i && status_o[B_QE]) |=> status_o[B_QE]);

   // R10: suspend and busy never coexist
   assert_sus_not_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      status_o[B_SUS] |-> !status_o[B_BUSY]);

   // R11: in power-down only the wake opcode acts
   assert_pd_lockout_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (power_down_o && !pwr_cycle_i && !(cmd_valid_i && cmd_code_i == OP_WAKE))
      |=> ($stable(status_o) && power_down_o && !rd_valid_o && !op_start_o));
endmodule

// File: tb/test_flash_status_ctrl.sv
`timescale 1ns/1ps
module test_flash_status_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pwr_cycle = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [7:0]  cmd_code = '0;
   logic [15:0] cmd_data = '0;
   logic        qpi = 1'b0;
   logic        wp_n = 1'b1;
   logic        op_done = 1'b0;
   logic [15:0] status;
   logic        pd, op_start, rd_valid;
   logic [7:0]  op_code, rd_byte;

   int n_run = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   flash_status_ctrl i_flash_status_ctrl (
      .clk_i(clk), .rst_ni(rst_n), .pwr_cycle_i(pwr_cycle),
      .cmd_valid_i(cmd_valid), .cmd_code_i(cmd_code), .cmd_data_i(cmd_data),
      .qpi_mode_i(qpi), .wp_ni(wp_n), .op_done_i(op_done),
      .status_o(status), .power_down_o(pd), .op_start_o(op_start),
      .op_code_o(op_code), .rd_valid_o(rd_valid), .rd_byte_o(rd_byte));

   // reference model state
   logic [15:0] m_nv;
   logic m_busy, m_sw, m_wel, m_sus, m_pd;
   logic e_start, e_rdv;
   logic [7:0] e_code, e_rdb;

   function automatic logic is_array(input logic [7:0] c);
      return c inside {8'h02, 8'h32, 8'h20, 8'h52, 8'hD8, 8'hC7, 8'h60, 8'h44, 8'h42};
   endfunction

   function automatic logic [15:0] m_status();
      return m_nv | {m_sus, 13'd0, m_wel, m_busy};
   endfunction

   task automatic model_clear();
      m_nv = '0; m_busy = 0; m_sw = 0; m_wel = 0; m_sus = 0; m_pd = 0;
      e_start = 0; e_rdv = 0; e_code = '0; e_rdb = '0;
   endtask

   task automatic model_apply(input logic v, input logic [7:0] c, input logic [15:0] d,
                              input logic dn, input logic pc);
      logic [15:0] s;
      s = m_status();
      e_start = 0; e_rdv = 0;
      if (pc) begin
         m_busy = 0; m_sw = 0; m_wel = 0; m_sus = 0; m_pd = 0;
         if (m_nv[8] && !m_nv[7]) m_nv[8] = 0;
      end else if (m_pd) begin
         if (v && c == 8'hAB) m_pd = 0;
      end else if (m_busy) begin
         if (v && (c == 8'h05 || c == 8'h35)) begin
            e_rdv = 1; e_rdb = (c == 8'h35) ? s[15:8] : s[7:0];
         end
         if (dn) begin m_busy = 0; m_wel = 0; end
         else if (v && c == 8'h75 && !m_sw) begin m_busy = 0; m_sus = 1; end
      end else if (v) begin
         case (c)
            8'h06: m_wel = 1;
            8'h04: m_wel = 0;
            8'h05: begin e_rdv = 1; e_rdb = s[7:0]; end
            8'h35: begin e_rdv = 1; e_rdb = s[15:8]; end
            8'hB9: begin m_pd = 1; m_sus = 0; end
            8'h7A: if (m_sus) begin m_sus = 0; m_busy = 1; end
            8'h01: if (m_wel && !m_sus && !m_nv[8] &&
                       !(m_nv[7] && !m_nv[9] && !wp_n)) begin
               m_nv = (d & 16'h41FC) | ((m_nv | d) & 16'h3800) |
                      {6'd0, d[9] | (qpi & m_nv[9]), 9'd0};
               m_busy = 1; m_sw = 1; e_start = 1; e_code = c;
            end
            default: if (is_array(c) && m_wel && !m_sus) begin
               m_busy = 1; m_sw = 0; e_start = 1; e_code = c;
            end
         endcase
      end
   endtask

   task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, got, exp);
      end
   endtask

   task automatic step(input logic v, input logic [7:0] c, input logic [15:0] d,
                       input logic dn, input logic pc);
      cmd_valid = v; cmd_code = c; cmd_data = d; op_done = dn; pwr_cycle = pc;
      model_apply(v, c, d, dn, pc);
      @(posedge clk); #1;
      cmd_valid = 0; op_done = 0; pwr_cycle = 0;
   endtask

   task automatic cmd(input logic [7:0] c);            step(1, c, 16'h0, 0, 0); endtask
   task automatic cmdd(input logic [7:0] c, input logic [15:0] d); step(1, c, d, 0, 0); endtask
   task automatic done_op();                          step(0, 8'h00, 16'h0, 1, 0); endtask
   task automatic pcyc();                             step(0, 8'h00, 16'h0, 0, 1); endtask

   task automatic do_reset();
      rst_n = 0; model_clear();
      @(posedge clk); #1;
      rst_n = 1;
   endtask

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      summary();
      $finish;
   end

   logic [7:0] pool [20];

   initial begin
      pool = '{8'h06, 8'h04, 8'h01, 8'h05, 8'h35, 8'h75, 8'h7A, 8'hB9, 8'hAB, 8'h02,
               8'h32, 8'h20, 8'h52, 8'hD8, 8'hC7, 8'h60, 8'h44, 8'h42, 8'h00, 8'h01};
      #1;
      do_reset();
      chk("R1 status", status, 16'h0000);
      chk("R1 pd", {15'd0, pd}, 16'h0);
      chk("R1 rd_valid/op_start", {14'd0, rd_valid, op_start}, 16'h0);

      cmdd(8'h01, 16'hFFFF);
      chk("R3 no wel status", status, 16'h0000);
      chk("R3 no wel start", {15'd0, op_start}, 16'h0);
      cmd(8'h06);  chk("R2 wren", status, 16'h0002);
      cmd(8'h04);  chk("R2 wrdi", status, 16'h0000);
      cmd(8'h06);  cmdd(8'h01, 16'hFFFF);
      chk("R3 start", {7'd0, op_start, op_code}, {7'd0, 1'b1, 8'h01});
      chk("R6 written bits", status, 16'h7BFF);
      cmd(8'h04);  chk("R5 wrdi ignored busy", status, 16'h7BFF);
      cmd(8'h35);
      chk("R13 high byte", {7'd0, rd_valid, rd_byte}, {7'd0, 1'b1, 8'h7B});
      cmd(8'h02);  chk("R5 prog ignored busy", {15'd0, op_start}, 16'h0);
      done_op();   chk("R4 done", status, 16'h7BFC);
      cmd(8'h06);  cmdd(8'h01, 16'h0000);
      chk("R9 srp1 blocks start", {15'd0, op_start}, 16'h0);
      chk("R9 srp1 blocks status", status, 16'h7BFE);
      pcyc();      chk("R12 srp 11 kept", status, 16'h7BFC);

      do_reset();
      cmd(8'h06);  cmdd(8'h01, 16'h3A00); chk("R7 set locks", status, 16'h3A03);
      done_op();   chk("R7 locks done", status, 16'h3A00);
      qpi = 1;
      cmd(8'h06);  cmdd(8'h01, 16'h0000); done_op();
      chk("R8 qe kept in qpi, R7 locks", status, 16'h3A00);
      qpi = 0;
      cmd(8'h06);  cmdd(8'h01, 16'h0000); done_op();
      chk("R8 qe cleared outside qpi", status, 16'h3800);
      cmd(8'h06);  cmdd(8'h01, 16'h0080); done_op();
      chk("R9 srp0 set", status, 16'h3880);
      wp_n = 0;
      cmd(8'h06);  cmdd(8'h01, 16'h0000);
      chk("R9 pin blocks", {status[14:0], op_start}, {15'h3882, 1'b0});
      wp_n = 1;
      cmdd(8'h01, 16'h0280); done_op();
      chk("R9 pin high allows", status, 16'h3A80);
      wp_n = 0;
      cmd(8'h06);  cmdd(8'h01, 16'h0284);
      chk("R9 qe overrides pin", {15'd0, op_start}, 16'h1);
      done_op();   chk("R9 qe override result", status, 16'h3A84);
      wp_n = 1;
      cmd(8'h06);  cmdd(8'h01, 16'h0100); done_op();
      chk("R12 srp 10 set", status, 16'h3900);
      cmd(8'h06);  pcyc();
      chk("R12 power cycle", status, 16'h3800);

      cmd(8'h06);  cmd(8'h02);
      chk("R3 program start", {7'd0, op_start, op_code}, {7'd0, 1'b1, 8'h02});
      cmd(8'h75);  chk("R10 suspend", status, 16'hB802);
      cmd(8'h02);  chk("R10 refused while suspended", {status[14:0], op_start}, {15'h3802, 1'b0});
      cmd(8'h7A);  chk("R10 resume", status, 16'h3803);
      done_op();   chk("R10 done after resume", status, 16'h3800);
      cmd(8'h06);  cmdd(8'h01, 16'h3800);
      cmd(8'h75);  chk("R10 no suspend of status write", status, 16'h3803);
      done_op();
      done_op();   chk("R4 done while idle", status, 16'h3800);

      cmd(8'h06);  cmd(8'hB9);
      chk("R11 power down", {15'd0, pd}, 16'h1);
      cmd(8'h04);  chk("R11 wrdi ignored", status, 16'h3802);
      cmd(8'h05);  chk("R11 read ignored", {15'd0, rd_valid}, 16'h0);
      cmd(8'hAB);  chk("R11 wake", {15'd0, pd}, 16'h0);
      cmd(8'h05);
      chk("R13 low byte", {7'd0, rd_valid, rd_byte}, {7'd0, 1'b1, 8'h02});
      cmd(8'h02);  cmd(8'h75); chk("R10 suspend again", status, 16'hB802);
      cmd(8'hB9);
      chk("R11 pd clears sus", {status, 15'd0, pd}, {16'h3802, 15'd0, 1'b1});
      pcyc();      chk("R12 clears pd", {status[14:0], pd}, {15'h3800, 1'b0});

      // random phase against the model
      do_reset();
      void'($urandom(32'd20240917));
      for (int i = 0; i < 6000; i++) begin
         logic [15:0] d;
         logic v;
         if ($urandom % 600 == 0) begin
            do_reset();
            chk("R1 random reset", status, 16'h0000);
            continue;
         end
         qpi  = ($urandom % 4 == 0);
         wp_n = ($urandom % 3 != 0);
         d = 16'($urandom);
         if ($urandom % 8 != 0) d[8] = 1'b0;
         v = ($urandom % 4 != 0);
         step(v, pool[$urandom % 20], d, ($urandom % 3 == 0), ($urandom % 97 == 0));
         chk("R5 random status", status, m_status());
         chk("R11 random pd", {15'd0, pd}, {15'd0, m_pd});
         chk("R3 random start", {15'd0, op_start}, {15'd0, e_start});
         if (e_start) chk("R3 random opcode", {8'd0, op_code}, {8'd0, e_code});
         chk("R13 random rd_valid", {15'd0, rd_valid}, {15'd0, e_rdv});
         if (e_rdv) chk("R13 random rd_byte", {8'd0, rd_byte}, {8'd0, e_rdb});
      end

      summary();
      $finish;
   end
endmodule